// File: doc/BRIEF.md
# Dual-Protocol Host Register Port

This block connects an 8-bit host microprocessor bus to a chip's internal control register file. A static protocol-select input chooses between two nonmultiplexed bus styles. In one style, separate active-low read and write strobes are used and an active-high ready line is pulled low while an access is in flight. In the other style, a single active-low data strobe is qualified by a read/write direction line, and an active-low acknowledge marks completion. All bus inputs are synchronized to the core clock before they are decoded. A transaction is therefore seen a fixed number of cycles after the host asserts its strobe.

The host sees only a small window of eight byte locations. Two of them hold the internal register address: a low byte and a few high bits. A third location is a data window. A host write to the data window launches one write of that byte into the internal register file, at the address held in the two address registers. A host read of the data window launches one internal fetch. The handshake is withheld until the internal access has run its fixed two-cycle sequence. Accesses to the address registers complete without touching the internal port. After each transaction the host must release its strobe before the block will accept the next one.

Top module: `hbus_regport`

## Requirements
- R1: After synchronous reset: `rdy`=1, `dtack_n`=1, `hdata_oe`=0, `ireg_we`=0, `ireg_re`=0, and both address registers read back 0.
- R2: With `mode_sel`=0 (strobe-pair protocol), a host access is requested when `cs_n`=0 and either `strb_n`=0 (read) or `wdir`=0 (write). `rdy` goes low combinationally as soon as a request is present and returns high when the access is acknowledged. `dtack_n` stays 1 throughout.
- R3: With `mode_sel`=1 (strobe-plus-direction protocol), a host access is requested when `cs_n`=0 and `strb_n`=0, with `wdir`=1 meaning read and `wdir`=0 meaning write. `dtack_n` goes low on acknowledge and stays low until the strobe is released. `rdy` stays 1 throughout.
- R4: The host offsets are 0 for the data window, 1 for the internal address bits [7:0], and 2 for the internal address bits [IAW-1:8], right-aligned and with the unused upper bits reading 0. Offsets 3 to 7 read 0, and writes to them have no effect.
- R5: A host write to offset 0 produces exactly one `ireg_we` pulse. During that pulse `ireg_addr` equals {high, low} and `ireg_wdata` equals the written byte.
- R6: A host read of offset 0 produces exactly one `ireg_re` pulse. The value returned on `hdata_out` is `ireg_rdata` as sampled one cycle after that pulse.
- R7: Counting rising clock edges from a strobe asserted between edges, the acknowledge appears after edge 3 for offsets 1 to 7 and after edge 5 for offset 0.
- R8: A strobe held active after acknowledge starts no further access, and the acknowledge persists until release.
- R9: `hdata_oe` is 1 only while a read is being acknowledged. It is 0 for writes and after release.
- R10: With `cs_n`=1, the strobe and direction lines have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | Static protocol select: 0 for the strobe pair, 1 for strobe plus direction |
| cs_n | input | 1 | Chip select, active low |
| strb_n | input | 1 | Read strobe (mode 0) or data strobe (mode 1), active low |
| wdir | input | 1 | Write strobe, active low (mode 0), or read/write direction with 1 meaning read (mode 1) |
| haddr | input | HAW | Host byte offset |
| hdata_in | input | DW | Host write data |
| hdata_out | output | DW | Host read data |
| hdata_oe | output | 1 | Host data drive enable |
| rdy | output | 1 | Ready, held low while busy (mode 0) |
| dtack_n | output | 1 | Acknowledge, active low (mode 1) |
| ireg_addr | output | IAW | Internal register address |
| ireg_wdata | output | DW | Internal write data |
| ireg_we | output | 1 | Internal write pulse |
| ireg_re | output | 1 | Internal read pulse |
| ireg_rdata | input | DW | Internal read data, valid one cycle after `ireg_re` |

## Verification
The bench builds the block with IAW=9, so that the whole 512-entry internal space can be written and read back in each protocol, using address-dependent byte patterns computed in the bench. A reset and a protocol switch between the phases show that the internal contents persist while the address registers clear. The bench also shows that data written in one protocol reads back correctly in the other. With a 1-bit high address register, the masking of the unused bits and every unused offset can be exercised exhaustively.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    typedef enum logic {
        BUS_PAIR = 1'b0,
        BUS_DIR  = 1'b1
    } bus_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_ACK  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic active;
        logic is_read;
    } bus_req_t;

    localparam logic [2:0] OFS_DATA    = 3'd0;
    localparam logic [2:0] OFS_ADDR_LO = 3'd1;
    localparam logic [2:0] OFS_ADDR_HI = 3'd2;

    localparam int ACC_CYC = 2;

    function automatic bus_req_t decode_bus(input bus_mode_e m, input logic cs_n,
                                            input logic strb_n, input logic wdir);
        bus_req_t r;
        r.active  = 1'b0;
        r.is_read = 1'b0;
        if (!cs_n) begin
            if (m == BUS_PAIR) begin
                r.active  = !strb_n || !wdir;
                r.is_read = !strb_n;
            end else begin
                r.active  = !strb_n;
                r.is_read = wdir;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
    parameter int WIDTH = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= RST_VAL;
                else     stg[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= RST_VAL;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hbus_decode.sv
module hbus_decode
    import hbus_pkg::*;
(
    input  logic     mode_sel,
    input  logic     cs_n,
    input  logic     strb_n,
    input  logic     wdir,
    output bus_req_t req
);
    assign req = decode_bus(bus_mode_e'(mode_sel), cs_n, strb_n, wdir);
endmodule

// File: rtl/hbus_seq.sv
module hbus_seq
    import hbus_pkg::*;
#(
    parameter int HAW = 3,
    parameter int DW  = 8,
    parameter int IAW = 10
) (
    input  logic           clk,
    input  logic           rst,
    input  bus_req_t       req,
    input  logic [HAW-1:0] haddr,
    input  logic [DW-1:0]  hdata_in,
    input  logic [DW-1:0]  ireg_rdata,
    output logic           ack,
    output logic           is_read_q,
    output logic [DW-1:0]  rd_q,
    output logic [IAW-1:0] ireg_addr,
    output logic [DW-1:0]  ireg_wdata,
    output logic           ireg_we,
    output logic           ireg_re
);
    localparam int HIW = IAW - DW;
    localparam int CW  = (ACC_CYC > 1) ? $clog2(ACC_CYC) : 1;

    seq_state_e     state;
    logic [CW-1:0]  cnt;
    logic [DW-1:0]  wbuf;
    logic [DW-1:0]  addr_lo;
    logic [HIW-1:0] addr_hi;
    logic [DW-1:0]  ext_rd;

    always_comb begin
        ext_rd = '0;
        if (haddr == HAW'(OFS_ADDR_LO))      ext_rd = addr_lo;
        else if (haddr == HAW'(OFS_ADDR_HI)) ext_rd = {{(DW-HIW){1'b0}}, addr_hi};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            wbuf      <= '0;
            addr_lo   <= '0;
            addr_hi   <= '0;
            rd_q      <= '0;
            is_read_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (req.active) begin
                    is_read_q <= req.is_read;
                    wbuf      <= hdata_in;
                    if (haddr == HAW'(OFS_DATA)) begin
                        state <= ST_ACC;
                        cnt   <= '0;
                    end else begin
                        state <= ST_ACK;
                        if (req.is_read) rd_q <= ext_rd;
                        else if (haddr == HAW'(OFS_ADDR_LO)) addr_lo <= hdata_in;
                        else if (haddr == HAW'(OFS_ADDR_HI)) addr_hi <= hdata_in[HIW-1:0];
                    end
                end
                ST_ACC: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CW'(ACC_CYC - 1)) begin
                        state <= ST_ACK;
                        if (is_read_q) rd_q <= ireg_rdata;
                    end
                end
                ST_ACK: if (!req.active) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign ack        = (state == ST_ACK);
    assign ireg_we    = (state == ST_ACC) && (cnt == '0) && !is_read_q;
    assign ireg_re    = (state == ST_ACC) && (cnt == '0) && is_read_q;
    assign ireg_addr  = {addr_hi, addr_lo};
    assign ireg_wdata = wbuf;

    // R5 / R6: an internal access is a single-cycle pulse
    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        (ireg_we || ireg_re) |=> !(ireg_we || ireg_re));
    assert_we_re_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(ireg_we && ireg_re));
    // R7: the access sequence runs for two cycles before the acknowledge
    assert_acc_len_R7: assert property (@(posedge clk) disable iff (rst)
        (ireg_we || ireg_re) |=> (state == ST_ACC) && !ack);
    // R8: the acknowledge is only left when the request is gone
    assert_ack_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (ack && req.active) |=> ack);
endmodule

// File: rtl/hbus_regport.sv
module hbus_regport
    import hbus_pkg::*;
#(
    parameter int HAW = 3,
    parameter int DW  = 8,
    parameter int IAW = 10
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           mode_sel,
    input  logic           cs_n,
    input  logic           strb_n,
    input  logic           wdir,
    input  logic [HAW-1:0] haddr,
    input  logic [DW-1:0]  hdata_in,
    output logic [DW-1:0]  hdata_out,
    output logic           hdata_oe,
    output logic           rdy,
    output logic           dtack_n,
    output logic [IAW-1:0] ireg_addr,
    output logic [DW-1:0]  ireg_wdata,
    output logic           ireg_we,
    output logic           ireg_re,
    input  logic [DW-1:0]  ireg_rdata
);
    logic [2:0] ctl_s;
    bus_req_t   req_s;
    bus_req_t   req_raw;
    logic       ack;
    logic       is_read_q;

    hbus_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b111)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cs_n, strb_n, wdir}),
        .q   (ctl_s)
    );

    hbus_decode u_dec (
        .mode_sel (mode_sel),
        .cs_n     (ctl_s[2]),
        .strb_n   (ctl_s[1]),
        .wdir     (ctl_s[0]),
        .req      (req_s)
    );

    hbus_seq #(.HAW(HAW), .DW(DW), .IAW(IAW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req        (req_s),
        .haddr      (haddr),
        .hdata_in   (hdata_in),
        .ireg_rdata (ireg_rdata),
        .ack        (ack),
        .is_read_q  (is_read_q),
        .rd_q       (hdata_out),
        .ireg_addr  (ireg_addr),
        .ireg_wdata (ireg_wdata),
        .ireg_we    (ireg_we),
        .ireg_re    (ireg_re)
    );

    assign req_raw  = decode_bus(bus_mode_e'(mode_sel), cs_n, strb_n, wdir);
    assign rdy      = !((mode_sel == BUS_PAIR) && req_raw.active && !ack);
    assign dtack_n  = !((mode_sel == BUS_DIR) && ack);
    assign hdata_oe = ack && is_read_q;

    // R2 / R3: each protocol leaves the other handshake idle
    assert_pair_no_dtack_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == BUS_PAIR) |-> dtack_n);
    assert_dir_rdy_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == BUS_DIR) |-> rdy);
    // R9: data is driven only inside an acknowledged read
    assert_oe_in_ack_R9: assert property (@(posedge clk) disable iff (rst)
        hdata_oe |-> (rdy && (dtack_n == (mode_sel == BUS_PAIR))));
endmodule

// File: tb/hbus_regport_tb.sv
`timescale 1ns/1ps
module hbus_regport_tb_top;
    localparam int HAW = 3;
    localparam int DW  = 8;
    localparam int IAW = 9;
    localparam int NADDR = 1 << IAW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_sel = 1'b0;
    logic cs_n = 1'b1, strb_n = 1'b1, wdir = 1'b1;
    logic [HAW-1:0] haddr = '0;
    logic [DW-1:0]  hdata_in = '0;
    logic [DW-1:0]  hdata_out;
    logic hdata_oe, rdy, dtack_n, ireg_we, ireg_re;
    logic [IAW-1:0] ireg_addr;
    logic [DW-1:0]  ireg_wdata;
    logic [DW-1:0]  ireg_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    hbus_regport #(.HAW(HAW), .DW(DW), .IAW(IAW)) dut_i (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .cs_n(cs_n), .strb_n(strb_n),
        .wdir(wdir), .haddr(haddr), .hdata_in(hdata_in), .hdata_out(hdata_out),
        .hdata_oe(hdata_oe), .rdy(rdy), .dtack_n(dtack_n), .ireg_addr(ireg_addr),
        .ireg_wdata(ireg_wdata), .ireg_we(ireg_we), .ireg_re(ireg_re),
        .ireg_rdata(ireg_rdata)
    );

    // internal register file model: one-cycle read latency
    logic [DW-1:0] mem [NADDR];
    int wr_cnt = 0, re_cnt = 0;
    logic [IAW-1:0] last_waddr = '0;
    logic [DW-1:0]  last_wdata = '0;
    always @(posedge clk) begin
        if (ireg_we) begin
            mem[ireg_addr] <= ireg_wdata;
            wr_cnt <= wr_cnt + 1;
            last_waddr <= ireg_addr;
            last_wdata <= ireg_wdata;
        end
        if (ireg_re) begin
            ireg_rdata <= mem[ireg_addr];
            re_cnt <= re_cnt + 1;
        end
    end

    function automatic logic [7:0] pat(input int a, input int k);
        return 8'((a * 37 + k * 11 + (a >> 3)) ^ (k * 90));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input bit rd, input logic [2:0] a, input logic [7:0] d,
                        input int hold, output logic [7:0] q);
        int lat, exp_lat;
        bit got;
        exp_lat = (a == 3'd0) ? 5 : 3;
        @(negedge clk);
        haddr = a; hdata_in = d; cs_n = 1'b0;
        if (!mode_sel) begin
            if (rd) strb_n = 1'b0; else wdir = 1'b0;
        end else begin
            wdir = rd; strb_n = 1'b0;
        end
        #1;
        if (!mode_sel) chk(rdy == 1'b0, "R2 rdy low on request", int'(rdy), 0);
        lat = 0; got = 0;
        while (!got && lat < 20) begin
            @(posedge clk); #1; lat++;
            if (!mode_sel) begin
                got = rdy;
                chk(dtack_n == 1'b1, "R2 dtack idle", int'(dtack_n), 1);
            end else begin
                got = !dtack_n;
                chk(rdy == 1'b1, "R3 rdy idle", int'(rdy), 1);
            end
        end
        chk(lat == exp_lat, "R7 ack latency", lat, exp_lat);
        chk(hdata_oe == rd, "R9 oe during ack", int'(hdata_oe), int'(rd));
        q = hdata_out;
        for (int i = 0; i < hold; i++) begin
            @(posedge clk); #1;
            chk(mode_sel ? !dtack_n : rdy, "R8 ack held", 0, 1);
        end
        @(negedge clk);
        cs_n = 1'b1; strb_n = 1'b1; wdir = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        chk(hdata_oe == 1'b0, "R9 oe off after release", int'(hdata_oe), 0);
        chk(rdy && dtack_n, "R2/R3 handshake idle after release", int'({rdy, dtack_n}), 3);
    endtask

    task automatic set_addr(input int ia);
        logic [7:0] q;
        xfer(0, 3'd1, 8'(ia), 0, q);
        xfer(0, 3'd2, 8'(ia >> 8), 0, q);
    endtask

    task automatic wr_data(input int ia, input logic [7:0] d);
        logic [7:0] q;
        int w0;
        set_addr(ia);
        w0 = wr_cnt;
        xfer(0, 3'd0, d, 0, q);
        chk(wr_cnt == w0 + 1, "R5 one write pulse", wr_cnt - w0, 1);
        chk(last_waddr == IAW'(ia), "R5 write address", int'(last_waddr), ia);
        chk(last_wdata == d, "R5 write data", int'(last_wdata), int'(d));
    endtask

    task automatic rd_data(input int ia, input logic [7:0] exp, input string tag);
        logic [7:0] q;
        int r0;
        set_addr(ia);
        r0 = re_cnt;
        xfer(1, 3'd0, 8'h00, 0, q);
        chk(re_cnt == r0 + 1, "R6 one read pulse", re_cnt - r0, 1);
        chk(q == exp, tag, int'(q), int'(exp));
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk(rdy == 1'b1, "R1 rdy", int'(rdy), 1);
        chk(dtack_n == 1'b1, "R1 dtack_n", int'(dtack_n), 1);
        chk(hdata_oe == 1'b0, "R1 oe", int'(hdata_oe), 0);
        chk(!ireg_we && !ireg_re, "R1 no access", int'({ireg_we, ireg_re}), 0);
    endtask

    task automatic chk_addr_regs_zero();
        logic [7:0] q;
        xfer(1, 3'd1, 8'h00, 0, q);
        chk(q == 8'h00, "R1 addr low cleared", int'(q), 0);
        xfer(1, 3'd2, 8'h00, 0, q);
        chk(q == 8'h00, "R1 addr high cleared", int'(q), 0);
    endtask

    initial begin
        logic [7:0] q;
        int w0, r0;
        do_reset();
        chk_addr_regs_zero();

        // strobe-pair protocol: fill and read back the whole space
        for (int a = 0; a < NADDR; a++) wr_data(a, pat(a, 1));
        for (int a = 0; a < NADDR; a++) rd_data(a, pat(a, 1), "R6 R2 readback");

        // R4: high register masking and unused offsets
        xfer(0, 3'd2, 8'hFF, 0, q);
        xfer(1, 3'd2, 8'h00, 0, q);
        chk(q == 8'h01, "R4 high bits masked", int'(q), 1);
        xfer(0, 3'd1, 8'hA5, 0, q);
        for (int o = 3; o < 8; o++) begin
            w0 = wr_cnt;
            xfer(0, 3'(o), 8'h5A, 0, q);
            xfer(1, 3'(o), 8'h00, 0, q);
            chk(q == 8'h00, "R4 unused offset reads 0", int'(q), 0);
            chk(wr_cnt == w0, "R4 unused offset no write", wr_cnt - w0, 0);
        end
        xfer(1, 3'd1, 8'h00, 0, q);
        chk(q == 8'hA5, "R4 addr low intact", int'(q), 'hA5);

        // R10: strobes without chip select
        w0 = wr_cnt; r0 = re_cnt;
        @(negedge clk); haddr = 3'd1; hdata_in = 8'h3C; wdir = 1'b0; strb_n = 1'b0;
        repeat (8) @(posedge clk);
        #1;
        chk(rdy == 1'b1, "R10 rdy without select", int'(rdy), 1);
        chk(wr_cnt == w0 && re_cnt == r0, "R10 no access", wr_cnt - w0, 0);
        @(negedge clk); wdir = 1'b1; strb_n = 1'b1;
        xfer(1, 3'd1, 8'h00, 0, q);
        chk(q == 8'hA5, "R10 addr low unchanged", int'(q), 'hA5);

        // R8: long-held strobe on a data read
        set_addr(7);
        r0 = re_cnt;
        xfer(1, 3'd0, 8'h00, 20, q);
        chk(re_cnt == r0 + 1, "R8 one fetch per strobe", re_cnt - r0, 1);
        chk(q == pat(7, 1), "R8 data", int'(q), int'(pat(7, 1)));

        // strobe-plus-direction protocol after reset
        mode_sel = 1'b1;
        do_reset();
        chk_addr_regs_zero();
        for (int a = 0; a < NADDR; a++) rd_data(a, pat(a, 1), "R3 R6 cross-protocol readback");
        for (int a = 0; a < NADDR; a++) wr_data(a, pat(a, 2));
        for (int a = 0; a < NADDR; a++) rd_data(a, pat(a, 2), "R3 R6 readback");

        w0 = wr_cnt;
        set_addr(300);
        xfer(0, 3'd0, 8'hC3, 15, q);
        chk(wr_cnt == w0 + 1, "R8 one write per strobe", wr_cnt - w0, 1);
        rd_data(300, 8'hC3, "R8 R3 held-write readback");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule